// File: doc/BRIEF.md
# Fractional-Rate Baud Tick Generator

This block turns a fast system clock into a stream of single-cycle tick pulses whose average rate approximates a serial baud rate. It does this with a phase accumulator instead of a modulo counter. Each enabled clock adds a fixed step to the low ACC_W bits of a register one bit wider than that. The carry that lands in the top bit is the tick, and the next sum discards it. When the ratio of clock to baud rate is not a whole number, the gap between ticks alternates between the two integers on either side of 2^ACC_W divided by the step. This keeps the long-run rate exact to the rounding of the step.

The nominal clock frequency, the target baud rate and the accumulator width are elaboration-time parameters, and the step is computed from them. A plain enable input pauses the block. While it is low, the accumulator keeps its whole state, including a carry that has not yet been reported, and the tick output stays low. A carry that is pending when the pause starts is therefore shown as a tick on the first enabled cycle after the pause. A serial transmitter or receiver uses the tick as its bit-rate strobe. The block has no data path, so it has no valid/ready interface, and every pin is a plain control signal.

Top module: `baud_tick_gen`

## Requirements
- R1: Reset is synchronous and active high, and it clears the accumulator. The tick output is low while reset is asserted and in the first cycle after reset is released.
- R2: The step is ((BAUD_HZ << (ACC_W-4)) + (CLK_HZ >> 5)) / (CLK_HZ >> 4), using integer division. For 2 MHz, 115200 baud and ACC_W=10 the step is 59. For 1.8432 MHz, 115200 baud and ACC_W=4 the step is 1. The step must lie between 1 and 2^(ACC_W-1).
- R3: A tick is exactly one cycle wide. The tick output is never high on two consecutive cycles.
- R4: The number of enabled cycles from one tick to the next is either floor(2^ACC_W/step) or ceil(2^ACC_W/step). For step 59 and ACC_W=10, this is 17 or 18.
- R5: After k enabled cycles since reset, the number of ticks reported or pending is floor(k·step / 2^ACC_W). Over N·2^ACC_W enabled cycles this is exactly N·step.
- R6: While the enable input is low, the accumulator holds its value and the tick output is low. A pending carry appears as a tick in the first enabled cycle after the pause.
- R7: When 2^ACC_W is a multiple of the step, the tick period is constant. For 1.8432 MHz, 115200 baud and ACC_W=4, the tick comes every 16 cycles.
- R8: With the block enabled throughout, the first tick after reset comes ceil(2^ACC_W/step) cycles after reset is released. For step 59 and ACC_W=10, that is 18 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk  | input     | 1     | System clock; every register updates on its rising edge |
| rst  | input     | 1     | Synchronous reset, active high; clears the accumulator |
| en   | input     | 1     | High lets the accumulator advance; low freezes it and masks the tick |
| tick | output    | 1     | One-cycle strobe at the average baud rate |

## Verification
The accumulator is the only register between the inputs and the tick. The tick for the k-th enabled rising edge is therefore visible from that edge until the next one. A change on the enable input masks or unmasks the tick in the same cycle, without waiting for an edge. The bench drives reset and enable on falling edges and reads the tick on the following falling edge, after exactly one rising edge has passed. It counts how many of those edges had enable high, and compares every sample against floor(k·step/2^ACC_W) - floor((k-1)·step/2^ACC_W), gated by the present enable value. A fractional configuration and an integer configuration run side by side, with steady enable and with an irregular enable pattern.

// File: rtl/baud_tick_pkg.sv
package baud_tick_pkg;

  // Rounded step: both operands pre-shifted so the intermediate stays small,
  // half the divisor added before division for round-to-nearest.
  function automatic longint unsigned calc_step(
    input longint unsigned clk_hz,
    input longint unsigned baud_hz,
    input int              acc_w
  );
    longint unsigned num;
    longint unsigned den;
    num = (baud_hz << (acc_w - 4)) + (clk_hz >> 5);
    den = clk_hz >> 4;
    return num / den;
  endfunction

endpackage

// File: rtl/baud_phase_acc.sv
module baud_phase_acc #(
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic [ACC_W-1:0] step,
  output logic [ACC_W:0]   acc_q
);

  logic [ACC_W:0] sum_next;

  // The carry bit of the previous result is dropped here, so it is reported once.
  always_comb begin
    sum_next = {1'b0, acc_q[ACC_W-1:0]} + {1'b0, step};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
    end else if (adv) begin
      acc_q <= sum_next;
    end
  end

endmodule

// File: rtl/baud_tick_gate.sv
module baud_tick_gate (
  input  logic carry,
  input  logic en,
  output logic tick
);

  // A carry held across a pause stays pending and is shown once enable returns.
  always_comb begin
    tick = carry & en;
  end

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_tick_pkg::*;
#(
  parameter longint unsigned CLK_HZ  = 25000000,
  parameter longint unsigned BAUD_HZ = 115200,
  parameter int              ACC_W   = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);

  localparam longint unsigned STEP_FULL = calc_step(CLK_HZ, BAUD_HZ, ACC_W);
  localparam logic [ACC_W-1:0] STEP     = STEP_FULL[ACC_W-1:0];
  localparam longint unsigned SPAN      = 64'd1 << ACC_W;
  localparam int GAP_LO = int'(SPAN / STEP_FULL);
  localparam int GAP_HI = ((SPAN % STEP_FULL) == 0) ? GAP_LO : GAP_LO + 1;

  logic [ACC_W:0] acc_q;

  baud_phase_acc #(
    .ACC_W(ACC_W)
  ) u_acc (
    .clk  (clk),
    .rst  (rst),
    .adv  (en),
    .step (STEP),
    .acc_q(acc_q)
  );

  baud_tick_gate u_gate (
    .carry(acc_q[ACC_W]),
    .en   (en),
    .tick (tick)
  );

endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk #(
  parameter int ACC_W  = 16,
  parameter int GAP_LO = 217,
  parameter int GAP_HI = 218
) (
  input logic           clk,
  input logic           rst,
  input logic           en,
  input logic           tick,
  input logic [ACC_W:0] acc
);

  int   gap;
  logic seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap  <= 0;
      seen <= 1'b0;
    end else if (en) begin
      if (tick) begin
        gap  <= 0;
        seen <= 1'b1;
      end else begin
        gap <= gap + 1;
      end
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk) rst |=> !tick);

  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

  assert_gap_bounds_R4: assert property (@(posedge clk) disable iff (rst)
    (tick && seen) |-> ((gap + 1 == GAP_LO) || (gap + 1 == GAP_HI)));

  assert_pause_masks_R6: assert property (@(posedge clk) disable iff (rst)
    !en |-> !tick);

  assert_pause_holds_R6: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(acc));

endmodule

bind baud_tick_gen baud_tick_gen_chk #(
  .ACC_W (ACC_W),
  .GAP_LO(GAP_LO),
  .GAP_HI(GAP_HI)
) u_chk (
  .clk (clk),
  .rst (rst),
  .en  (en),
  .tick(tick),
  .acc (acc_q)
);

// File: tb/tb_baud_tick_gen.sv
module tb_baud_tick_gen;

  localparam longint A_CLK = 2000000;
  localparam int     A_W   = 10;
  localparam longint B_CLK = 1843200;
  localparam int     B_W   = 4;
  localparam longint BAUD  = 115200;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b1;
  logic tick_a;
  logic tick_b;
  int   checks = 0;
  int   errors = 0;
  bit   done   = 1'b0;

  always #10 clk = ~clk;

  baud_tick_gen #(.CLK_HZ(A_CLK), .BAUD_HZ(BAUD), .ACC_W(A_W)) dut (
    .clk(clk), .rst(rst), .en(en), .tick(tick_a));

  baud_tick_gen #(.CLK_HZ(B_CLK), .BAUD_HZ(BAUD), .ACC_W(B_W)) dut16 (
    .clk(clk), .rst(rst), .en(en), .tick(tick_b));

  function automatic longint ref_step(longint c, longint b, int w);
    return ((b << (w - 4)) + (c >> 5)) / (c >> 4);
  endfunction

  function automatic bit want_carry(longint k, longint s, int w);
    if (k < 1) return 1'b0;
    return ((k * s) >> w) != (((k - 1) * s) >> w);
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    longint sa, sb, e, cnt_a, cnt_b, last_a, last_b, lo, hi;
    sa = ref_step(A_CLK, BAUD, A_W);
    sb = ref_step(B_CLK, BAUD, B_W);
    chk(sa == 59, "R2 step fractional", sa, 59);
    chk(sb == 1, "R2 step integer", sb, 1);
    lo = (64'd1 << A_W) / sa;
    hi = lo + 1;

    // R1: reset holds tick low
    rst = 1'b1; en = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk(tick_a == 1'b0, "R1 during reset", tick_a, 0);
      chk(tick_b == 1'b0, "R1 during reset int", tick_b, 0);
    end
    rst = 1'b0;
    #1;
    chk(tick_a == 1'b0, "R1 first cycle after reset", tick_a, 0);

    // Steady enable over 4 * 2^W cycles
    cnt_a = 0; cnt_b = 0; last_a = 0; last_b = 0;
    for (int k = 1; k <= 4096; k++) begin
      @(negedge clk);
      chk(tick_a == want_carry(k, sa, A_W), "R5 tick stream", tick_a, want_carry(k, sa, A_W));
      chk(tick_b == want_carry(k, sb, B_W), "R7 tick stream int", tick_b, want_carry(k, sb, B_W));
      if (tick_a) begin
        cnt_a++;
        if (last_a == 0) chk(k == 18, "R8 first tick", k, 18);
        else begin
          chk((k - last_a == lo) || (k - last_a == hi), "R4 spacing", k - last_a, lo);
          chk(k - last_a > 1, "R3 single pulse", k - last_a, 2);
        end
        last_a = k;
      end
      if (tick_b) begin
        cnt_b++;
        if (last_b != 0) chk(k - last_b == 16, "R7 constant period", k - last_b, 16);
        last_b = k;
      end
    end
    chk(cnt_a == 4 * sa, "R5 window count", cnt_a, 4 * sa);
    chk(cnt_b == 256 * sb, "R7 window count", cnt_b, 256 * sb);

    // R6: irregular enable pattern
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    chk(tick_a == 1'b0, "R1 re-reset", tick_a, 0);
    rst = 1'b0;
    e = 0; cnt_a = 0;
    for (int c = 0; c < 4000; c++) begin
      bit prev_en;
      prev_en = en;
      @(negedge clk);
      if (prev_en) e++;
      chk(tick_a == (en && want_carry(e, sa, A_W)), "R6 gated stream", tick_a,
          en && want_carry(e, sa, A_W));
      if (!en) chk(tick_a == 1'b0, "R6 masked", tick_a, 0);
      if (tick_a) cnt_a++;
      en = !((c % 7 == 3) || (c % 7 == 4) || (c % 11 == 5));
    end

    // R6: pause exactly on a pending tick, then resume
    en = 1'b1;
    for (int g = 0; g < 40 && !tick_a; g++) @(negedge clk);
    chk(tick_a == 1'b1, "R6 found pending tick", tick_a, 1);
    en = 1'b0;
    for (int h = 0; h < 20; h++) begin
      @(negedge clk);
      chk(tick_a == 1'b0, "R6 tick masked in pause", tick_a, 0);
    end
    en = 1'b1;
    #1;
    chk(tick_a == 1'b1, "R6 pending tick kept", tick_a, 1);
    @(negedge clk);
    chk(tick_a == 1'b0, "R3 no repeat after resume", tick_a, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks + 1, errors + 1);
      $finish;
    end
  end

endmodule